// File: doc/BRIEF.md
# Fixed-Priority Burst Bus Arbiter

This block decides which of several requesters may use a shared memory-write bus. Typical requesters are DMA engines and camera interfaces that each move a long burst. Each requester raises its bit of `req` and keeps it high until it is served. A registered priority stage reduces the request vector to a one-hot winner and a flag that shows whether anyone is asking. A small state machine watches that flag. When the bus is free it latches the winner into `grant` and keeps it there for the whole burst. The granted master pulses `done` at the end of its burst, and the arbiter then picks a new winner.

The priority stage is built from identical four-input slices. A "taken" signal runs through the slices in a chain, so the number of requesters grows in steps of four. Resolution costs two clock edges, which is small next to a burst of several hundred words. A requester must drop its request no later than the cycle in which it pulses `done`.

Top module: `burst_arb`

## Requirements
- R1: Among all active request bits, the lowest index wins. Bit 0 has the highest priority and bit NUM_REQ-1 the lowest.
- R2: A request that arrives while the arbiter is idle shows up in `grant` and `busy` on the second rising edge after it is first sampled. The request is sampled at edge 1, and `grant` and `busy` update at edge 2.
- R3: `grant` is never more than one-hot. Whenever `busy` is 1, exactly one bit of `grant` is set, and that bit was requesting.
- R4: After reset, and whenever `busy` is 0, `grant` is all zeros.
- R5: While `busy` is 1 and `done` is 0, `grant` does not change, whatever happens on `req`.
- R6: A `done` pulse while `busy` is 1 clears `busy` and `grant` on the next rising edge.
- R7: The resolved winner does not keep an old value. If no request is active when `done` arrives, the arbiter stays idle with `grant` at zero.
- R8: An active-low asynchronous reset (`rstN` = 0) clears `grant`, `busy` and the resolver state at once, even in the middle of a burst.
- R9: The number of requesters is the parameter NUM_REQ. The highest index, which sits in the last slice, can be granted when it is the only requester.
- R10: A `done` pulse while the arbiter is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | NUM_REQ | Request vector; bit i belongs to requester i |
| done | input | 1 | One-cycle end-of-burst pulse from the granted master |
| grant | output | NUM_REQ | One-hot grant; held for the whole burst |
| busy | output | 1 | 1 while a burst is granted |

## Verification
On every cycle, the assertions check that `grant` is at most one-hot, that it is zero and nonzero in step with `busy`, and that it stays stable during a burst. They also check that `done` releases the bus one edge later, and that a newly granted bit was requesting two edges earlier. Only the directed scenarios can show some behaviours. These are the choice of the lowest active index under many request patterns (compared with a first-set-bit model), the exact two-edge latency, the lack of a stale winner after release, the effect of asynchronous reset in the middle of a burst, and that `done` is ignored while idle.

// File: rtl/burst_arb_pkg.sv
package burst_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_BUSY  = 2'd2
  } arbState_e;

  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
  } ctrlStrobe_t;
endpackage

// File: rtl/burst_arb_slice4.sv
// Four-input fixed-priority slice; bit 0 is strongest, takenIn blocks all.
module burst_arb_slice4 (
  input  logic [3:0] reqIn,
  input  logic       takenIn,
  output logic [3:0] winOut,
  output logic       takenOut
);
  always_comb begin
    winOut[0] = reqIn[0] & ~takenIn;
    winOut[1] = reqIn[1] & ~takenIn & ~reqIn[0];
    winOut[2] = reqIn[2] & ~takenIn & ~(|reqIn[1:0]);
    winOut[3] = reqIn[3] & ~takenIn & ~(|reqIn[2:0]);
    takenOut  = takenIn | (|reqIn);
  end
endmodule

// File: rtl/burst_arb_datapath.sv
module burst_arb_datapath
  import burst_arb_pkg::*;
#(
  parameter int NUM_REQ = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] req,
  input  ctrlStrobe_t        strobe,
  output logic               anyReq,
  output logic [NUM_REQ-1:0] grant
);
  localparam int NUM_SLICE = (NUM_REQ + 3) / 4;
  localparam int PAD_W     = NUM_SLICE * 4;

  logic [PAD_W-1:0]   reqPad;
  logic [PAD_W-1:0]   winPad;
  logic [NUM_SLICE:0] takenChain;
  logic [NUM_REQ-1:0] winnerQ;
  logic               anyQ;
  logic [NUM_REQ-1:0] grantQ;

  always_comb begin
    reqPad              = '0;
    reqPad[NUM_REQ-1:0] = req;
  end

  assign takenChain[0] = 1'b0;

  for (genvar s = 0; s < NUM_SLICE; s++) begin : gSlice
    burst_arb_slice4 uSlice (
      .reqIn   (reqPad[4*s +: 4]),
      .takenIn (takenChain[s]),
      .winOut  (winPad[4*s +: 4]),
      .takenOut(takenChain[s+1])
    );
  end

  // Registered resolver: cleared every cycle without requests.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winnerQ <= '0;
      anyQ    <= 1'b0;
    end else begin
      winnerQ <= winPad[NUM_REQ-1:0];
      anyQ    <= takenChain[NUM_SLICE];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  grantQ <= '0;
    else if (strobe.clearGrant) grantQ <= '0;
    else if (strobe.loadGrant)  grantQ <= winnerQ;
  end

  assign anyReq = anyQ;
  assign grant  = grantQ;
endmodule

// File: rtl/burst_arb_ctrl.sv
module burst_arb_ctrl
  import burst_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyReq,
  input  logic        done,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  arbState_e stateQ, stateD;

  always_comb begin
    stateD            = stateQ;
    strobe.loadGrant  = 1'b0;
    strobe.clearGrant = 1'b0;
    case (stateQ)
      ST_IDLE: if (anyReq) begin
        stateD           = ST_GRANT;
        strobe.loadGrant = 1'b1;
      end
      ST_GRANT: begin
        if (done) begin
          stateD            = ST_IDLE;
          strobe.clearGrant = 1'b1;
        end else begin
          stateD = ST_BUSY;
        end
      end
      ST_BUSY: if (done) begin
        stateD            = ST_IDLE;
        strobe.clearGrant = 1'b1;
      end
      default: begin
        stateD            = ST_IDLE;
        strobe.clearGrant = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);
endmodule

// File: rtl/burst_arb.sv
module burst_arb
  import burst_arb_pkg::*;
#(
  parameter int NUM_REQ = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] req,
  input  logic               done,
  output logic [NUM_REQ-1:0] grant,
  output logic               busy
);
  ctrlStrobe_t strobe;
  logic        anyReq;

  burst_arb_datapath #(.NUM_REQ(NUM_REQ)) uDatapath (
    .clk   (clk),
    .rstN  (rstN),
    .req   (req),
    .strobe(strobe),
    .anyReq(anyReq),
    .grant (grant)
  );

  burst_arb_ctrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .anyReq(anyReq),
    .done  (done),
    .strobe(strobe),
    .busy  (busy)
  );
endmodule

// File: rtl/burst_arb_chk.sv
module burst_arb_chk #(
  parameter int NUM_REQ = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] req,
  input logic               done,
  input logic [NUM_REQ-1:0] grant,
  input logic               busy
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R3

  AST_BUSY_HAS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (grant != '0)); // R3

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (grant == '0)); // R4

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(grant)); // R5

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && done) |=> (!busy && grant == '0)); // R6

  AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ((grant & $past(req, 2)) != '0)); // R2
endmodule

bind burst_arb burst_arb_chk #(.NUM_REQ(NUM_REQ)) uChk (
  .clk  (clk),
  .rstN (rstN),
  .req  (req),
  .done (done),
  .grant(grant),
  .busy (busy)
);

// File: tb/tb_burst_arb.sv
`timescale 1ns/1ps
module tb_burst_arb;
  localparam int NUM_REQ = 24;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_REQ-1:0] req = '0;
  logic               done = 1'b0;
  logic [NUM_REQ-1:0] grant;
  logic               busy;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  burst_arb #(.NUM_REQ(NUM_REQ)) dut (
    .clk(clk), .rstN(rstN), .req(req), .done(done), .grant(grant), .busy(busy)
  );

  always #10 clk = ~clk;

  function automatic logic [NUM_REQ-1:0] firstSet(input logic [NUM_REQ-1:0] p);
    logic [NUM_REQ-1:0] r = '0;
    for (int i = 0; i < NUM_REQ; i++) if (p[i]) begin r[i] = 1'b1; break; end
    return r;
  endfunction

  task automatic check(input string tag, input logic [NUM_REQ-1:0] act,
                       input logic [NUM_REQ-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive done with requests dropped, then check the bus is released.
  task automatic finishBurst(input string tag);
    done = 1'b1; req = '0;
    tick(1);
    done = 1'b0;
    check({tag, " busy"}, NUM_REQ'(busy), '0);
    check({tag, " grant"}, grant, '0);
    tick(2);
  endtask

  // Apply a pattern while idle and check grant after two rising edges.
  task automatic arbitrate(input string tag, input logic [NUM_REQ-1:0] p);
    req = p;
    tick(2);
    check({tag, " grant"}, grant, firstSet(p));
    check({tag, " busy"}, NUM_REQ'(busy), NUM_REQ'(1));
    finishBurst({tag, " release"});
  endtask

  task automatic testReset();
    check("R4 reset grant", grant, '0);
    check("R4 reset busy", NUM_REQ'(busy), '0);
  endtask

  task automatic testLatency();
    req = 24'h000010;
    tick(1);
    check("R2 not yet after 1 edge", NUM_REQ'(busy), '0);
    tick(1);
    check("R2 grant at edge 2", grant, 24'h000010);
    check("R2 busy at edge 2", NUM_REQ'(busy), NUM_REQ'(1));
    finishBurst("R6 after latency");
  endtask

  task automatic testPriority();
    arbitrate("R1 two low", 24'h000006);
    arbitrate("R1 across slices", 24'h880100);
    arbitrate("R1 all set", 24'hFFFFFF);
    arbitrate("R1 bit0 with high", 24'h800001);
    arbitrate("R9 top only", 24'h800000);
  endtask

  task automatic testRandom();
    for (int k = 0; k < 40; k++) begin
      logic [NUM_REQ-1:0] p = NUM_REQ'($urandom);
      if (p == '0) p[7] = 1'b1;
      arbitrate("R1 random", p);
    end
  endtask

  task automatic testHold();
    req = 24'h000020;
    tick(2);
    check("R5 initial grant", grant, 24'h000020);
    req = 24'h000021;
    tick(3);
    check("R5 hold vs higher request", grant, 24'h000020);
    req = 24'h000000;
    tick(2);
    check("R5 hold with no request", grant, 24'h000020);
    finishBurst("R6 after hold");
  endtask

  task automatic testNoStale();
    req = 24'h000100;
    tick(2);
    finishBurst("R7 release");
    tick(3);
    check("R7 stays idle grant", grant, '0);
    check("R7 stays idle busy", NUM_REQ'(busy), '0);
  endtask

  task automatic testDoneIdle();
    done = 1'b1;
    tick(1);
    done = 1'b0;
    tick(1);
    check("R10 done while idle busy", NUM_REQ'(busy), '0);
    req = 24'h000400;
    tick(2);
    check("R10 grant after idle done", grant, 24'h000400);
    finishBurst("R10 release");
  endtask

  task automatic testAsyncReset();
    req = 24'h001000;
    tick(3);
    #3 rstN = 1'b0;
    #2;
    check("R8 async grant", grant, '0);
    check("R8 async busy", NUM_REQ'(busy), '0);
    req = '0;
    tick(1);
    rstN = 1'b1;
    tick(2);
    check("R8 idle after reset", NUM_REQ'(busy), '0);
  endtask

  initial begin
    tick(2);
    testReset();
    rstN = 1'b1;
    tick(2);
    testReset();
    testLatency();
    testPriority();
    testRandom();
    testHold();
    testNoStale();
    testDoneIdle();
    testAsyncReset();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule